// File: doc/BRIEF.md
# Automatic serial transfer interval controller

This block sends and receives a run of bytes over a clocked serial link with no help from software once it is started. It makes the serial clock itself from the CPU clock. Every bit time is two equal half-periods, and the length of one half-period in CPU cycles comes from the `sck_half` input. Each byte goes out on `sdo` and comes in on `sdi` at the same time, most significant bit first. The serial clock rests high. Data out changes when the clock falls, and data in is captured when the clock rises.

Between two bytes the block holds the serial clock high for a gap, counted in CPU cycles. The gap is the largest of three values:
- a floor of 2.5 serial-clock periods, which is exactly `5 * sck_half` cycles;
- a CPU cost that depends on the processing class in force when the byte ends;
- a programmed interval, when that interval is enabled.

No gap follows the last byte. The block raises `done` for one cycle and goes back to idle.

The controller has four states:
- `ST_IDLE` waits for an accepted start. An accepted start moves it to `ST_SHIFT`.
- `ST_SHIFT` clocks one byte. At the end of the byte it moves to `ST_GAP` if more bytes remain. After the last byte it moves to `ST_DONE`.
- `ST_GAP` counts the inter-byte gap. When the count runs out it moves back to `ST_SHIFT`, and the clock falls for the next byte.
- `ST_DONE` lasts one cycle and always moves to `ST_IDLE`.

Top module: `auto_xfer_ctrl`

## Requirements
- R1: Transmit byte k is `tx_data[8k+7:8k]`, and bytes go out in the order k = 0, 1, and so on. Each byte appears on `sdo` most significant bit first, and `sdo` is valid at every rising edge of `sck`.
- R2: The bit sampled from `sdi` at the i-th rising edge of byte k (i = 0..7) is stored in bit 7-i of `rx_data[8k+7:8k]`. The stored byte holds until it is overwritten by a later transfer.
- R3: `sck` is high while idle. Within a byte, every low phase and every high phase lasts exactly `sck_half` CPU cycles. A transfer starts with a falling edge, and each byte has 8 rising edges.
- R4: A start pulse is accepted only in idle, with `int_clk_sel` = 1 and `byte_cnt` between 1 and the maximum byte count. Otherwise `sck` stays high and no `done` appears.
- R5: `sck` stays high for G CPU cycles from the last rising edge of one byte to the first falling edge of the next, where G = max(5*`sck_half`, cost).
  - The cost depends on the class code: 0 (other) = 7, 1 (multiply) = 13, 2 (divide) = 20, 3 (external access with one wait) = 9.
- R6: With `iv_en` = 1, G is also at least `iv_len`. With `iv_en` = 0, `iv_len` has no effect.
- R7: The class code is sampled at the end of each byte. Each gap uses the class present at the end of the byte just before it.
- R8: After the last byte there is no gap. `done` is high for exactly one cycle, `sck_half` cycles after the final rising edge. The block then returns to idle, with no further clock edges.
- R9: A start pulse that arrives while a transfer runs is ignored. The transfer keeps its original byte count, and `done` appears only once.
- R10: After reset, `sck` = 1, `done` = 0 and `rx_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse for a transfer |
| int_clk_sel | input | 1 | Must be 1 for internal-clock automatic operation |
| byte_cnt | input | CNT_W | Number of bytes to transfer |
| tx_data | input | 8*MAX_BYTES | Transmit bytes, with byte 0 in the low bits |
| sck_half | input | DIV_W | Serial-clock half-period in CPU cycles |
| proc_class | input | 2 | Processing class code |
| iv_en | input | 1 | Enable for the programmed minimum interval |
| iv_len | input | IV_W | Programmed minimum interval in CPU cycles |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Serial clock, high when idle |
| sdo | output | 1 | Serial data out |
| rx_data | output | 8*MAX_BYTES | Received bytes, with byte 0 in the low bits |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The assertions take for granted that `sck_half` is nonzero and holds steady while a transfer is running. Without that, the half-period count and the gap bound would have no meaning. The stimulus sets `sck_half`, `iv_len` and `byte_cnt` only while the block is idle. The one exception is the deliberate `byte_cnt` change that comes with the ignored start pulse. The class code is changed mid-transfer only when the test is about class sampling, and only while a byte is being shifted.

// File: rtl/axc_pkg.sv
package axc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2,
        ST_DONE  = 2'd3
    } axc_state_e;

    typedef enum logic [1:0] {
        CLS_OTHER = 2'd0,
        CLS_MUL   = 2'd1,
        CLS_DIV   = 2'd2,
        CLS_XWAIT = 2'd3
    } axc_class_e;

    localparam int COST_W = 5;

    // CPU cycles charged for each processing class
    function automatic logic [COST_W-1:0] class_cost(input logic [1:0] cls);
        logic [COST_W-1:0] c;
        unique case (axc_class_e'(cls))
            CLS_MUL:   c = 5'd13;
            CLS_DIV:   c = 5'd20;
            CLS_XWAIT: c = 5'd9;
            default:   c = 5'd7;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/axc_sck_gen.sv
module axc_sck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             active,
    input  logic [DIV_W-1:0] sck_half,
    output logic             sck,
    output logic             rise_now,
    output logic             fall_now,
    output logic             end_now
);
    localparam int BIT_W = 3;

    logic [DIV_W-1:0] hc_q;
    logic             ph_q;
    logic [BIT_W-1:0] bc_q;
    logic             sck_q;
    logic             half_up;

    always_comb begin
        half_up  = active && (hc_q == sck_half - DIV_W'(1));
        rise_now = half_up && !ph_q;
        fall_now = half_up && ph_q && (bc_q != 3'd7);
        end_now  = half_up && ph_q && (bc_q == 3'd7);
        sck      = sck_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b1;
            hc_q  <= '0;
            ph_q  <= 1'b0;
            bc_q  <= '0;
        end else if (launch) begin
            sck_q <= 1'b0;
            hc_q  <= '0;
            ph_q  <= 1'b0;
            bc_q  <= '0;
        end else if (active) begin
            if (half_up) begin
                hc_q <= '0;
                if (!ph_q) begin
                    sck_q <= 1'b1;
                    ph_q  <= 1'b1;
                end else if (bc_q != 3'd7) begin
                    sck_q <= 1'b0;
                    ph_q  <= 1'b0;
                    bc_q  <= bc_q + 3'd1;
                end
            end else begin
                hc_q <= hc_q + DIV_W'(1);
            end
        end
    end

    // Input assumption: a running byte needs a nonzero half-period (R3)
    p_half_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (sck_half != '0));

    // A byte that has just ended leaves the clock high (R3)
    p_end_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        end_now |=> sck_q);

endmodule

// File: rtl/axc_shifter.sv
module axc_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  logic [7:0] tx_byte,
    input  logic       fall_now,
    input  logic       rise_now,
    input  logic       sdi,
    output logic       sdo,
    output logic [7:0] rx_byte
);
    logic [7:0] tsr_q;
    logic [7:0] rsr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tsr_q <= '0;
            rsr_q <= '0;
        end else begin
            if (launch) begin
                tsr_q <= tx_byte;
            end else if (fall_now) begin
                tsr_q <= {tsr_q[6:0], 1'b0};
            end
            if (rise_now) begin
                rsr_q <= {rsr_q[6:0], sdi};
            end
        end
    end

    always_comb begin
        sdo     = tsr_q[7];
        rx_byte = rsr_q;
    end

    // Data out moves only on a falling edge or a byte launch (R1)
    p_sdo_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!launch && !fall_now) |=> $stable(sdo));

endmodule

// File: rtl/axc_gap_timer.sv
module axc_gap_timer #(
    parameter int DIV_W = 8,
    parameter int IV_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [1:0]       proc_class,
    input  logic             iv_en,
    input  logic [IV_W-1:0]  iv_len,
    input  logic [DIV_W-1:0] sck_half,
    output logic             expire
);
    import axc_pkg::*;

    localparam int GW0   = (DIV_W > IV_W) ? DIV_W : IV_W;
    localparam int GAP_W = ((GW0 > COST_W) ? GW0 : COST_W) + 4;

    logic [GAP_W-1:0] half_x;
    logic [GAP_W-1:0] floor_x;
    logic [GAP_W-1:0] cost_x;
    logic [GAP_W-1:0] iv_x;
    logic [GAP_W-1:0] g_a;
    logic [GAP_W-1:0] g_x;
    logic [GAP_W-1:0] cnt_q;

    always_comb begin
        half_x  = GAP_W'(sck_half);
        floor_x = (half_x << 2) + half_x;
        cost_x  = GAP_W'(class_cost(proc_class));
        iv_x    = iv_en ? GAP_W'(iv_len) : '0;
        g_a     = (floor_x > cost_x) ? floor_x : cost_x;
        g_x     = (g_a > iv_x) ? g_a : iv_x;
        expire  = (cnt_q == '0);
    end

    // The final high phase already spent sck_half cycles of the gap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= g_x - half_x - GAP_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - GAP_W'(1);
        end
    end

    p_gap_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q + $past(half_x) + GAP_W'(1)) >= (($past(half_x) << 2) + $past(half_x)));

    p_gap_cost_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q + $past(half_x) + GAP_W'(1)) >= GAP_W'(class_cost($past(proc_class))));

    p_gap_iv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && iv_en) |=> (cnt_q + $past(half_x) + GAP_W'(1)) >= GAP_W'($past(iv_len)));

endmodule

// File: rtl/auto_xfer_ctrl.sv
module auto_xfer_ctrl #(
    parameter int MAX_BYTES = 4,
    parameter int DIV_W     = 8,
    parameter int IV_W      = 8,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   int_clk_sel,
    input  logic [CNT_W-1:0]       byte_cnt,
    input  logic [8*MAX_BYTES-1:0] tx_data,
    input  logic [DIV_W-1:0]       sck_half,
    input  logic [1:0]             proc_class,
    input  logic                   iv_en,
    input  logic [IV_W-1:0]        iv_len,
    input  logic                   sdi,
    output logic                   sck,
    output logic                   sdo,
    output logic [8*MAX_BYTES-1:0] rx_data,
    output logic                   done
);
    import axc_pkg::*;

    localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

    axc_state_e       state_q, state_d;
    logic [CNT_W-1:0] rem_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] tx_sel;
    logic [7:0]       tx_byte;
    logic [7:0]       rx_byte;
    logic [MAX_BYTES-1:0][7:0] rx_q;
    logic             start_ok;
    logic             launch;
    logic             gap_load;
    logic             active;
    logic             rise_now, fall_now, end_now;
    logic             gap_expire;
    logic             last_byte;

    always_comb begin
        start_ok  = start && int_clk_sel && (byte_cnt != '0) &&
                    (byte_cnt <= CNT_W'(MAX_BYTES));
        last_byte = (rem_q == CNT_W'(1));
        tx_sel    = (state_q == ST_IDLE) ? '0 : idx_q;
        tx_byte   = tx_data[8*tx_sel +: 8];
    end

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        launch   = 1'b0;
        gap_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) begin
                    state_d = ST_SHIFT;
                    launch  = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (end_now) begin
                    if (last_byte) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d  = ST_GAP;
                        gap_load = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (gap_expire) begin
                    state_d = ST_SHIFT;
                    launch  = 1'b1;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and transfer bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            idx_q   <= '0;
            rx_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_ok) begin
                rem_q <= byte_cnt;
                idx_q <= '0;
            end else if (end_now) begin
                rem_q       <= rem_q - CNT_W'(1);
                idx_q       <= idx_q + IDX_W'(1);
                rx_q[idx_q] <= rx_byte;
            end
        end
    end

    // Outputs
    always_comb begin
        active  = (state_q == ST_SHIFT);
        done    = (state_q == ST_DONE);
        rx_data = rx_q;
    end

    axc_sck_gen #(.DIV_W(DIV_W)) u_sck (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .active   (active),
        .sck_half (sck_half),
        .sck      (sck),
        .rise_now (rise_now),
        .fall_now (fall_now),
        .end_now  (end_now)
    );

    axc_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .tx_byte  (tx_byte),
        .fall_now (fall_now),
        .rise_now (rise_now),
        .sdi      (sdi),
        .sdo      (sdo),
        .rx_byte  (rx_byte)
    );

    axc_gap_timer #(.DIV_W(DIV_W), .IV_W(IV_W)) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (gap_load),
        .proc_class (proc_class),
        .iv_en      (iv_en),
        .iv_len     (iv_len),
        .sck_half   (sck_half),
        .expire     (gap_expire)
    );

    p_idle_sck_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> sck);

    p_gap_sck_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> sck);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && sck));

    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (state_q == ST_SHIFT || state_q == ST_GAP)) |=> (state_q != ST_IDLE));

    p_half_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_d != ST_IDLE) |=> $stable(sck_half));

endmodule

// File: tb/auto_xfer_ctrl_bench.sv
module auto_xfer_ctrl_bench;

    localparam int MAXB  = 4;
    localparam int CNT_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             int_clk_sel = 1'b1;
    logic [CNT_W-1:0] byte_cnt = '0;
    logic [31:0]      tx_data = '0;
    logic [7:0]       sck_half = 8'd1;
    logic [1:0]       proc_class = 2'd0;
    logic             iv_en = 1'b0;
    logic [7:0]       iv_len = '0;
    logic             sdi = 1'b0;
    logic             sck, sdo, done;
    logic [31:0]      rx_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    auto_xfer_ctrl u_auto_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .int_clk_sel(int_clk_sel),
        .byte_cnt(byte_cnt), .tx_data(tx_data), .sck_half(sck_half),
        .proc_class(proc_class), .iv_en(iv_en), .iv_len(iv_len), .sdi(sdi),
        .sck(sck), .sdo(sdo), .rx_data(rx_data), .done(done)
    );

    // Serial-side monitor and slave model
    bit [7:0] srx [0:7];
    bit [7:0] cap [0:7];
    int hruns [0:63];
    int lruns [0:63];
    int rises, falls, hi_run, lo_run, done_cnt, done_hi;
    bit prev_sck = 1'b1;

    always @(negedge clk) begin
        if (done) begin
            done_cnt = done_cnt + 1;
            done_hi  = hi_run;
        end
        if (sck && !prev_sck) begin
            if (rises < 64) begin
                cap[rises/8][7 - rises%8] = sdo;
                lruns[rises] = lo_run;
            end
            rises  = rises + 1;
            hi_run = 1;
        end else if (sck) begin
            hi_run = hi_run + 1;
        end
        if (!sck && prev_sck) begin
            if (falls < 64) begin
                hruns[falls] = hi_run;
                sdi = srx[falls/8][7 - falls%8];
            end
            falls  = falls + 1;
            lo_run = 1;
        end else if (!sck) begin
            lo_run = lo_run + 1;
        end
        prev_sck = sck;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_gap(input int h, input int c, input bit ie, input int iv);
        int g;
        int cost;
        case (c)
            1: cost = 13;
            2: cost = 20;
            3: cost = 9;
            default: cost = 7;
        endcase
        g = (5*h > cost) ? 5*h : cost;
        if (ie && iv > g) g = iv;
        return g;
    endfunction

    task automatic clear_mon();
        rises = 0; falls = 0; hi_run = 0; lo_run = 0; done_cnt = 0; done_hi = -1;
        for (int i = 0; i < 8; i++) cap[i] = 8'h00;
    endtask

    // Runs one transfer; sw_at/inj_at < 0 disable the mid-run class switch and start pulse
    task automatic run_xfer(input int n, input int h, input int c, input bit ie,
                            input int iv, input int sw_at, input int sw_cls,
                            input int inj_at);
        bit injected = 0;
        int fz;
        byte_cnt = CNT_W'(n); sck_half = 8'(h); proc_class = 2'(c);
        iv_en = ie; iv_len = 8'(iv); int_clk_sel = 1'b1;
        clear_mon();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 6000; t++) begin
            @(negedge clk);
            if (done_cnt > 0) break;
            if (sw_at >= 0 && falls >= sw_at) proc_class = 2'(sw_cls);
            if (start) begin
                start = 1'b0;
                byte_cnt = CNT_W'(n);
            end
            if (inj_at >= 0 && !injected && falls >= inj_at) begin
                injected = 1;
                start = 1'b1;
                byte_cnt = CNT_W'(MAXB);
            end
        end
        start = 1'b0;
        fz = falls;
        repeat (12) @(negedge clk);
        chk(done_cnt == 1, "R8", "done pulse count", done_cnt, 1);
        chk(done_hi == h, "R8", "cycles from last rise to done", done_hi, h);
        chk(falls == fz && sck, "R8", "no clock after done", falls, fz);
        chk(falls == 8*n, "R3", "falling edges", falls, 8*n);
        chk(rises == 8*n, "R3", "rising edges", rises, 8*n);
    endtask

    task automatic check_phases(input int n, input int h);
        int bad = 0;
        for (int k = 0; k < 8*n; k++) begin
            if (lruns[k] != h) bad++;
            if (k % 8 != 0 && hruns[k] != h) bad++;
        end
        chk(bad == 0, "R3", "phase lengths off", bad, 0);
    endtask

    task automatic check_data(input int n);
        for (int b = 0; b < n; b++) begin
            chk(cap[b] == tx_data[8*b +: 8], "R1", "tx byte msb first", cap[b], tx_data[8*b +: 8]);
            chk(rx_data[8*b +: 8] == srx[b], "R2", "rx byte", rx_data[8*b +: 8], srx[b]);
        end
    endtask

    task automatic check_gap(input int b, input int g, input string req);
        chk(hruns[8*(b+1)] == g, req, "gap cycles", hruns[8*(b+1)], g);
    endtask

    task automatic t_reset();
        chk(sck == 1'b1, "R10", "sck at reset", sck, 1);
        chk(done == 1'b0, "R10", "done at reset", done, 0);
        chk(rx_data == 32'h0, "R10", "rx_data at reset", rx_data, 0);
    endtask

    task automatic t_basic();
        tx_data = 32'h0F_3C_A5_81;
        srx[0] = 8'h5A; srx[1] = 8'hC3; srx[2] = 8'h81; srx[3] = 8'h00;
        run_xfer(3, 2, 0, 0, 0, -1, 0, -1);
        check_phases(3, 2);
        check_data(3);
        check_gap(0, exp_gap(2, 0, 0, 0), "R5");
        check_gap(1, exp_gap(2, 0, 0, 0), "R5");
    endtask

    task automatic t_full();
        tx_data = 32'h96_01_FE_7E;
        srx[0] = 8'h01; srx[1] = 8'h80; srx[2] = 8'hFF; srx[3] = 8'h69;
        run_xfer(4, 3, 1, 0, 0, -1, 0, -1);
        check_phases(4, 3);
        check_data(4);
        for (int b = 0; b < 3; b++) check_gap(b, exp_gap(3, 1, 0, 0), "R5");
    endtask

    task automatic t_classes();
        tx_data = 32'h0000_C33C;
        srx[0] = 8'hAA; srx[1] = 8'h55;
        for (int c = 0; c < 4; c++) begin
            run_xfer(2, 1, c, 0, 0, -1, 0, -1);
            check_gap(0, exp_gap(1, c, 0, 0), "R5");
        end
    endtask

    task automatic t_floor();
        run_xfer(2, 4, 2, 0, 0, -1, 0, -1);
        check_gap(0, exp_gap(4, 2, 0, 0), "R5");
        run_xfer(2, 5, 2, 0, 0, -1, 0, -1);
        check_gap(0, exp_gap(5, 2, 0, 0), "R5");
        check_phases(2, 5);
    endtask

    task automatic t_interval();
        run_xfer(2, 1, 0, 1, 30, -1, 0, -1);
        check_gap(0, 30, "R6");
        run_xfer(2, 1, 0, 1, 3, -1, 0, -1);
        check_gap(0, 7, "R6");
        run_xfer(2, 1, 0, 0, 30, -1, 0, -1);
        check_gap(0, 7, "R6");
    endtask

    task automatic t_class_sample();
        tx_data = 32'h00_11_22_33;
        srx[0] = 8'h12; srx[1] = 8'h34; srx[2] = 8'h56;
        run_xfer(3, 1, 1, 0, 0, 10, 2, -1);
        check_gap(0, 13, "R7");
        check_gap(1, 20, "R7");
        proc_class = 2'd0;
    endtask

    task automatic t_busy_start();
        tx_data = 32'h00_00_E7_18;
        srx[0] = 8'h0F; srx[1] = 8'hF0;
        run_xfer(2, 2, 0, 0, 0, -1, 0, 4);
        chk(falls == 16, "R9", "edges after ignored start", falls, 16);
        check_data(2);
    endtask

    task automatic t_gate();
        int_clk_sel = 1'b0; byte_cnt = 3'd2;
        clear_mon();
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        chk(falls == 0 && done_cnt == 0 && sck, "R4", "start with external select", falls, 0);
        int_clk_sel = 1'b1; byte_cnt = 3'd0;
        clear_mon();
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        chk(falls == 0 && done_cnt == 0 && sck, "R4", "start with zero count", falls, 0);
        byte_cnt = 3'd5;
        clear_mon();
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        chk(falls == 0 && done_cnt == 0 && sck, "R4", "start with count over max", falls, 0);
    endtask

    initial begin
        clear_mon();
        for (int i = 0; i < 8; i++) srx[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_full();
        t_classes();
        t_floor();
        t_interval();
        t_class_sample();
        t_busy_start();
        t_gate();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule